// File: doc/BRIEF.md
# Power Switch Protection Sequencer

This block supervises a single power transistor from its gate-drive side. It follows a registered control level and keeps a top-level on or off mode that always matches it. Every change of the control level sends the block back to the first substate of the new mode and restarts all of its timers. Each timer then opens a further protection check. Digitised samples of collector voltage (full-range and fine-range channels) and gate voltage arrive together under one valid strobe. A gate-current comparator flag and a supply-good flag come in as plain levels.

In the on mode the block first waits for the collector transient to settle. It then sums four full-range samples to check for a short circuit, checks the fine-range collector voltage for overload on every sample, and checks the gate voltage once the gate-settling time has passed. In the off mode only the gate voltage is watched, after the same settling time. Any fault removes the driver enable and issues a one-cycle event carrying a class code that a feedback encoder turns into a pulse length. Supply-type faults also drive a level that stays high for as long as the condition lasts.

Top module: `switch_guard_seq`

## Requirements
- R1: After reset the block is in off mode, substate 1. `drv_en_o` is 1, and `flt_evt_o` and `flt_hold_o` are 0.
- R2: A change of `ctrl_i` is registered as a control edge. It discards any partial four-sample sum and ignores a sample strobed in the same cycle. A later short-circuit check uses only samples taken after the latest edge.
- R3: In on mode substate 1, once SC_CYC cycles have passed since the edge, the next four valid full-range samples are summed. A sum above 4*SC_TH raises an event of class 2 (collector). A sum equal to or below 4*SC_TH moves the block to substate 2.
- R4: In on-mode substates 2 and 3, a valid sample with `vce_fine_i` above OVL_TH raises a class 2 event. A reading equal to OVL_TH does not.
- R5: In on mode, GATE_CYC cycles after the edge, the block moves from substate 2 to substate 3. There a `vge_i` outside [VGE_ON_LO, VGE_ON_HI] raises a class 1 (gate) event. Before that time the gate voltage is not checked.
- R6: In off mode, GATE_CYC cycles after the edge, the block enters substate 2. There a sample with `vge_i` outside [VGE_OFF_LO, VGE_OFF_HI] sets `flt_hold_o` with a class 3 event. The hold clears at the next valid sample that is back inside the window.
- R7: If the enable was active at an edge and `gi_flag_i` is not seen within GI_CYC cycles, a class 1 event is raised.
- R8: `sup_ok_i` low in any substate sets `flt_hold_o` on the next clock edge. Each rise of `flt_hold_o` comes with a class 3 event.
- R9: Every fault clears `drv_en_o` in the same cycle as its event. The enable returns only after a cycle in which `ctrl_i` is 0 and no hold condition is present.
- R10: If the control level toggles faster than SC_CYC, no timed check runs. Such toggling raises no event, even when the collector and gate samples are out of range.
- R11: There is one event per fault occurrence, with class 1 = gate, 2 = collector, 3 = supply-type, and never class 0. Checks that latch a fault are suspended while the enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 1 | Commanded switch level, 1 = on |
| smp_valid_i | input | 1 | Strobe: the three sample inputs are valid |
| vce_full_i | input | ADC_W | Collector voltage, full-range channel code |
| vce_fine_i | input | ADC_W | Collector voltage, fine-range channel code |
| vge_i | input | ADC_W | Gate voltage code |
| gi_flag_i | input | 1 | Gate-current comparator output |
| sup_ok_i | input | 1 | Driver supply inside its allowed range |
| drv_en_o | output | 1 | Enable to the gate driver stage |
| flt_evt_o | output | 1 | One-cycle fault event |
| flt_cls_o | output | 2 | Class of the event: 1 gate, 2 collector, 3 supply-type |
| flt_hold_o | output | 1 | Supply-type fault currently present |

## Verification
The hardest state to reach is a four-sample average left half-done when a control edge arrives. It needs a commanded on interval long enough for the short-circuit timer to expire, exactly two strobed samples, and then an edge with proper gate-current pulses. The stimulus builds this by hand: it waits past the timer with no samples, feeds two high readings, toggles the control twice, and then supplies four low readings. A stale partial sum would then produce a collector event. The sum-equal-to-threshold and one-code-above cases are also placed by hand, right after the timer expiry.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_GATE   = 2'd1,
        CLS_COLL   = 2'd2,
        CLS_SUPPLY = 2'd3
    } flt_cls_e;

    typedef enum logic [1:0] {
        SUB1 = 2'd0,
        SUB2 = 2'd1,
        SUB3 = 2'd2
    } sub_e;

    typedef struct packed {
        logic     mode_on;
        sub_e     sub;
        logic     ctrl;
        logic     lock;
        logic     hold;
        logic     goff_bad;
        logic     gi_arm;
        logic     gi_seen;
        logic     evt;
        flt_cls_e cls;
    } seq_st_t;

endpackage

// File: rtl/sg_timer.sv
module sg_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)        cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/sg_accum.sv
module sg_accum #(
    parameter int W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           add_i,
    input  logic [W-1:0]   data_i,
    output logic           last_o,
    output logic [W+1:0]   total_o
);
    localparam int SW = W + 2;

    logic [1:0]    cnt_d, cnt_q;
    logic [SW-1:0] sum_d, sum_q;

    assign total_o = sum_q + SW'(data_i);
    assign last_o  = add_i && (cnt_q == 2'd3);

    always_comb begin
        cnt_d = cnt_q;
        sum_d = sum_q;
        if (clr_i || last_o) begin
            cnt_d = '0;
            sum_d = '0;
        end else if (add_i) begin
            cnt_d = cnt_q + 2'd1;
            sum_d = total_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            sum_q <= sum_d;
        end
    end
endmodule

// File: rtl/switch_guard_seq.sv
module switch_guard_seq
    import sg_pkg::*;
#(
    parameter int ADC_W      = 10,
    parameter int SC_CYC     = 200,
    parameter int GATE_CYC   = 1000,
    parameter int GI_CYC     = 25,
    parameter int SC_TH      = 340,
    parameter int OVL_TH     = 400,
    parameter int VGE_ON_LO  = 700,
    parameter int VGE_ON_HI  = 900,
    parameter int VGE_OFF_LO = 100,
    parameter int VGE_OFF_HI = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_i,
    input  logic             smp_valid_i,
    input  logic [ADC_W-1:0] vce_full_i,
    input  logic [ADC_W-1:0] vce_fine_i,
    input  logic [ADC_W-1:0] vge_i,
    input  logic             gi_flag_i,
    input  logic             sup_ok_i,
    output logic             drv_en_o,
    output logic             flt_evt_o,
    output logic [1:0]       flt_cls_o,
    output logic             flt_hold_o
);
    localparam int SUM_W  = ADC_W + 2;
    localparam int NTMR   = 3;
    localparam int T_SC   = 0;
    localparam int T_GATE = 1;
    localparam int T_GI   = 2;

    localparam logic [SUM_W-1:0] SC_SUM = SUM_W'(SC_TH * 4);
    localparam logic [ADC_W-1:0] OVL_C  = ADC_W'(OVL_TH);
    localparam logic [ADC_W-1:0] ON_LO  = ADC_W'(VGE_ON_LO);
    localparam logic [ADC_W-1:0] ON_HI  = ADC_W'(VGE_ON_HI);
    localparam logic [ADC_W-1:0] OFF_LO = ADC_W'(VGE_OFF_LO);
    localparam logic [ADC_W-1:0] OFF_HI = ADC_W'(VGE_OFF_HI);

    localparam seq_st_t RST_ST = '{
        mode_on: 1'b0, sub: SUB1, ctrl: 1'b0, lock: 1'b0, hold: 1'b0,
        goff_bad: 1'b0, gi_arm: 1'b0, gi_seen: 1'b0, evt: 1'b0, cls: CLS_NONE
    };

    function automatic int tmr_limit(int idx);
        case (idx)
            T_SC:    return SC_CYC;
            T_GATE:  return GATE_CYC;
            default: return GI_CYC;
        endcase
    endfunction

    seq_st_t q, d;

    logic             ctl_edge;
    logic [NTMR-1:0]  tmr_exp;
    logic             acc_add;
    logic             acc_last;
    logic [SUM_W-1:0] acc_total;
    logic             chk_ok;
    logic             smp_ok;
    logic             flt_lat;
    flt_cls_e         lat_cls;

    assign ctl_edge = (ctrl_i != q.ctrl);

    // Short-circuit delay, gate settling and gate-current window timers
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        sg_timer #(.LIMIT(tmr_limit(g))) i_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (ctl_edge),
            .expired_o (tmr_exp[g])
        );
    end

    assign chk_ok  = !q.lock && !q.hold && !ctl_edge;
    assign smp_ok  = smp_valid_i && !ctl_edge;
    assign acc_add = smp_ok && chk_ok && q.mode_on && (q.sub == SUB1) && tmr_exp[T_SC];

    sg_accum #(.W(ADC_W)) i_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ctl_edge),
        .add_i   (acc_add),
        .data_i  (vce_full_i),
        .last_o  (acc_last),
        .total_o (acc_total)
    );

    always_comb begin
        d       = q;
        d.ctrl  = ctrl_i;
        d.evt   = 1'b0;
        d.cls   = CLS_NONE;
        flt_lat = 1'b0;
        lat_cls = CLS_NONE;

        if (ctl_edge) begin
            d.mode_on  = ctrl_i;
            d.sub      = SUB1;
            d.goff_bad = 1'b0;
            d.gi_arm   = !q.lock;
            d.gi_seen  = 1'b0;
        end else begin
            if (gi_flag_i) d.gi_seen = 1'b1;
            if (q.gi_arm && tmr_exp[T_GI]) begin
                d.gi_arm = 1'b0;
                if (!q.gi_seen && !gi_flag_i && chk_ok) begin
                    flt_lat = 1'b1;
                    lat_cls = CLS_GATE;
                end
            end
            if (q.mode_on) begin
                if (q.sub == SUB1 && acc_last) begin
                    if (acc_total > SC_SUM) begin
                        flt_lat = 1'b1;
                        lat_cls = CLS_COLL;
                    end else begin
                        d.sub = SUB2;
                    end
                end
                if (q.sub == SUB2 && tmr_exp[T_GATE]) d.sub = SUB3;
                if (smp_ok && chk_ok && q.sub != SUB1 && vce_fine_i > OVL_C) begin
                    flt_lat = 1'b1;
                    lat_cls = CLS_COLL;
                end
                if (smp_ok && chk_ok && q.sub == SUB3 && (vge_i < ON_LO || vge_i > ON_HI)) begin
                    flt_lat = 1'b1;
                    lat_cls = CLS_GATE;
                end
            end else begin
                if (q.sub == SUB1 && tmr_exp[T_GATE]) d.sub = SUB2;
                if (smp_ok && q.sub == SUB2) d.goff_bad = (vge_i < OFF_LO) || (vge_i > OFF_HI);
            end
        end

        d.hold = !sup_ok_i || d.goff_bad;

        if (flt_lat) begin
            d.evt = 1'b1;
            d.cls = lat_cls;
        end
        if (d.hold && !q.hold) begin
            d.evt = 1'b1;
            d.cls = CLS_SUPPLY;
        end

        d.lock = flt_lat || d.hold || (q.lock && !(!ctrl_i && !d.hold));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    assign drv_en_o   = !q.lock;
    assign flt_evt_o  = q.evt;
    assign flt_cls_o  = q.cls;
    assign flt_hold_o = q.hold;
endmodule

// File: rtl/sg_seq_chk.sv
module sg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_i,
    input logic       sup_ok_i,
    input logic       drv_en_o,
    input logic       flt_evt_o,
    input logic [1:0] flt_cls_o,
    input logic       flt_hold_o
);
    // R11: an event always carries a class
    a_r11_evt_has_cls: assert property (@(posedge clk) disable iff (!rst_n)
        flt_evt_o |-> flt_cls_o != 2'd0);

    // R9: every event coincides with a removed enable
    a_r9_evt_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
        flt_evt_o |-> !drv_en_o);

    // R9: enable comes back only after an off command
    a_r9_restore_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> !$past(ctrl_i));

    // R9: a present hold keeps the enable removed
    a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flt_hold_o |-> !drv_en_o);

    // R8: supply loss shows up as a hold on the next edge
    a_r8_supply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok_i |=> flt_hold_o);

    // R6: each new hold is announced with a supply-type event
    a_r6_hold_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_hold_o) |-> (flt_evt_o && flt_cls_o == 2'd3));
endmodule

bind switch_guard_seq sg_seq_chk i_sg_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_i     (ctrl_i),
    .sup_ok_i   (sup_ok_i),
    .drv_en_o   (drv_en_o),
    .flt_evt_o  (flt_evt_o),
    .flt_cls_o  (flt_cls_o),
    .flt_hold_o (flt_hold_o)
);

// File: tb/test_switch_guard_seq.sv
module test_switch_guard_seq;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] vfull = '0;
    logic [W-1:0] vfine = '0;
    logic [W-1:0] vge = 10'd200;
    logic         gi = 1'b0;
    logic         sup_ok = 1'b1;
    logic         drv_en, evt, hold;
    logic [1:0]   cls;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    int    exp_cls[$];
    string exp_tag[$];
    int bg_full = 50, bg_fine = 100, bg_vge = 200;

    always #10 clk = ~clk;

    switch_guard_seq i_switch_guard_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .smp_valid_i(valid),
        .vce_full_i(vfull), .vce_fine_i(vfine), .vge_i(vge),
        .gi_flag_i(gi), .sup_ok_i(sup_ok), .drv_en_o(drv_en),
        .flt_evt_o(evt), .flt_cls_o(cls), .flt_hold_o(hold)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(input int f, input int fi, input int g);
        @(negedge clk);
        vfull = W'(f); vfine = W'(fi); vge = W'(g); valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        cyc(2);
    endtask

    task automatic run(input int n);
        repeat (n / 4) smp(bg_full, bg_fine, bg_vge);
    endtask

    task automatic set_ctrl(input bit lvl, input bit pulse_gi);
        @(negedge clk);
        ctrl = lvl;
        cyc(3);
        gi = pulse_gi;
        cyc(2);
        gi = 1'b0;
    endtask

    task automatic expect_evt(input int c, input string tag);
        exp_cls.push_back(c);
        exp_tag.push_back(tag);
    endtask

    task automatic drain(input string tag);
        check(exp_cls.size() == 0, {tag, " expected event missing"}, exp_cls.size(), 0);
        exp_cls.delete();
        exp_tag.delete();
    endtask

    task automatic chk_en(input bit e, input string tag);
        check(drv_en == e, {tag, " drv_en"}, drv_en, e);
    endtask

    // Scoreboard monitor: each event pops one expected item
    always @(negedge clk) begin
        if (rst_n && evt) begin
            if (exp_cls.size() == 0) begin
                check(1'b0, "R11 unexpected event class", cls, 0);
            end else begin
                string t;
                int    c;
                c = exp_cls.pop_front();
                t = exp_tag.pop_front();
                check(cls == 2'(c), {t, " event class"}, cls, c);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk_en(1'b1, "R1");
        check(hold == 1'b0, "R1 hold", hold, 0);
        check(evt == 1'b0, "R1 evt", evt, 0);
        run(1200);
        chk_en(1'b1, "R6 off window in range");

        // Normal on/off cycle
        bg_vge = 800;
        set_ctrl(1'b1, 1'b1);
        run(1300);
        chk_en(1'b1, "R3 R4 R5 normal on");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b1);
        run(1300);
        chk_en(1'b1, "R6 normal off");
        drain("R11 normal");

        // R3: sum equal to threshold passes
        bg_vge = 800;
        set_ctrl(1'b1, 1'b1);
        cyc(250);
        smp(400, 100, 800); smp(400, 100, 800); smp(400, 100, 800); smp(160, 100, 800);
        run(40);
        chk_en(1'b1, "R3 equal sum");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b1);
        run(100);

        // R3: one code above fails, R9 lock and release
        bg_vge = 800;
        set_ctrl(1'b1, 1'b1);
        cyc(250);
        expect_evt(2, "R3 short circuit");
        smp(400, 100, 800); smp(400, 100, 800); smp(400, 100, 800); smp(161, 100, 800);
        cyc(2);
        chk_en(1'b0, "R9 after short circuit");
        cyc(50);
        chk_en(1'b0, "R9 held while on");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b0);
        cyc(3);
        chk_en(1'b1, "R9 released at off");
        drain("R3");

        // R4 overload boundary
        bg_vge = 800; bg_fine = 400;
        set_ctrl(1'b1, 1'b1);
        run(600);
        chk_en(1'b1, "R4 equal no fault");
        expect_evt(2, "R4 overload");
        smp(50, 401, 800);
        cyc(2);
        chk_en(1'b0, "R4 overload");
        bg_fine = 100; bg_vge = 200;
        set_ctrl(1'b0, 1'b0);
        cyc(5);
        drain("R4");

        // R5 gate window only after settling time
        bg_vge = 950;
        set_ctrl(1'b1, 1'b1);
        run(600);
        chk_en(1'b1, "R5 not checked before settle");
        expect_evt(1, "R5 gate window");
        run(600);
        chk_en(1'b0, "R5 gate window");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b0);
        cyc(5);
        drain("R5");
        chk_en(1'b1, "R5 released");

        // R7 missing gate current
        bg_vge = 800;
        expect_evt(1, "R7 no gate current");
        set_ctrl(1'b1, 1'b0);
        cyc(40);
        chk_en(1'b0, "R7 no gate current");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b0);
        cyc(5);
        drain("R7");
        chk_en(1'b1, "R7 released");

        // R8 supply loss in off mode
        run(1200);
        expect_evt(3, "R8 supply off mode");
        sup_ok = 1'b0;
        cyc(4);
        chk_en(1'b0, "R8 supply loss");
        check(hold == 1'b1, "R8 hold", hold, 1);
        cyc(20);
        sup_ok = 1'b1;
        cyc(3);
        check(hold == 1'b0, "R8 hold cleared", hold, 0);
        chk_en(1'b1, "R8 restored");
        drain("R8");

        // R9 supply loss while on: stays off until off command
        bg_vge = 800;
        set_ctrl(1'b1, 1'b1);
        run(100);
        expect_evt(3, "R8 supply on mode");
        sup_ok = 1'b0;
        cyc(5);
        sup_ok = 1'b1;
        cyc(5);
        check(hold == 1'b0, "R9 hold cleared while on", hold, 0);
        chk_en(1'b0, "R9 still locked while on");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b0);
        cyc(3);
        chk_en(1'b1, "R9 released at off");
        drain("R9");

        // R6 gate-off window hold
        run(1200);
        expect_evt(3, "R6 off gate hold");
        smp(50, 100, 500);
        check(hold == 1'b1, "R6 hold set", hold, 1);
        chk_en(1'b0, "R6 hold");
        run(8);
        check(hold == 1'b0, "R6 hold cleared", hold, 0);
        chk_en(1'b1, "R6 restored");
        drain("R6");

        // R10 short intervals: no timed checks
        bg_full = 1000; bg_fine = 1000; bg_vge = 500;
        for (int i = 0; i < 12; i++) begin
            set_ctrl(~ctrl, 1'b1);
            run(96);
        end
        bg_full = 50; bg_fine = 100; bg_vge = 200;
        run(20);
        chk_en(1'b1, "R10 short intervals");
        drain("R10");

        // R2 partial average discarded by an edge
        bg_vge = 800;
        set_ctrl(1'b1, 1'b1);
        cyc(250);
        smp(1000, 100, 800); smp(1000, 100, 800);
        set_ctrl(1'b0, 1'b1);
        cyc(20);
        set_ctrl(1'b1, 1'b1);
        cyc(250);
        smp(100, 100, 800); smp(100, 100, 800); smp(100, 100, 800); smp(100, 100, 800);
        run(20);
        chk_en(1'b1, "R2 partial sum discarded");
        bg_vge = 200;
        set_ctrl(1'b0, 1'b1);
        run(20);
        drain("R2");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule